// File: doc/BRIEF.md
# Timer Capture/Compare PWM Channel

This block is one channel of a free-running 16-bit timer. The channel is set up through a small 8-bit register bus. It runs in one of two roles. As an input capture, it latches the timer count when a chosen edge arrives on a synchronised input pin. As an output compare, it compares the count with a stored channel value and drives an output pin, either by toggling it or as a PWM waveform. The timer period is set by a modulo input. The counter runs from zero up to that value and then wraps.

The 16-bit channel value is reached as two bytes. A small lock state machine keeps two-byte accesses coherent:

- **LK_OPEN** is the idle state.
- **LK_CAPHOLD** is entered by the transition *cap_freeze*. This is a high-byte read in capture mode. The state blocks new captures. The transition *cap_release* (a low-byte read) or a control write returns to LK_OPEN.
- **LK_CMPHOLD** is entered by the transition *cmp_freeze*. This is a high-byte write in a compare mode. The state blocks compare matches. The transition *cmp_release* (a low-byte write) or a control write returns to LK_OPEN.

In PWM operation, a full-duty request bit can hold the output at its active level. A change to this request only takes effect at the next counter wrap, so each period is either fully forced or fully normal.

Top module: `tcc_channel`

## Requirements
- R1: After reset the counter steps up by one each cycle from 0. In the cycle where its value is greater than or equal to `period_max`, it wraps to 0 on the next cycle. That wrap cycle is the overflow.
- R2: The bus map is: address 0 is the channel value high byte, address 1 is the low byte, address 2 is control, and address 3 reads as 0. Control bits are [1:0] mode, [3:2] edge select, [4] toggle-on-overflow and [5] full-duty request. Only these six bits are stored and read back.
- R3: Mode 00 is input capture. In mode 00, the counter value is stored in the channel register on a qualified edge of `cap_pin` after a two-flop synchroniser. The edge select chooses the qualified edges: 00 none, 01 rising, 10 falling, 11 both. The stored value is the count present two clock edges after the pin changes.
- R4: In capture mode, reading the high byte stops all captures until the low byte is read. A read of the low byte then returns the byte that belongs with the high byte already read.
- R5: Modes 10 and 11 are PWM. The output goes high at overflow and low on the cycle after a compare match. With compare value C and modulo M, the output is high for C+1 of every M+1 cycles when C < M, and high for the whole period when C ≥ M.
- R6: In any non-zero mode, writing the high byte stops compare matches until the low byte is written.
- R7: With toggle-on-overflow at 0 in PWM mode, setting the full-duty request forces the output high from the first overflow after the write. The rest of the period in which the write happens is unaffected.
- R8: After the full-duty request is cleared, the output stays forced high until the next overflow. Normal PWM resumes after that overflow.
- R9: With toggle-on-overflow at 1 in PWM mode, overflow toggles the output instead of setting it, and the full-duty request has no effect.
- R10: Mode 01 toggles the output on every compare match, so with C < M the output high time over two consecutive periods adds up to exactly one period.
- R11: During reset the counter reads 0, the output is low and the control register reads 0. The channel value has no reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe (side effects only; data is combinational) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| period_max | input | 16 | Modulo value: last count of a period |
| cap_pin | input | 1 | Asynchronous capture input |
| tmr_count | output | 16 | Current counter value |
| ch_out | output | 1 | Channel output pin |

## Verification
The assertions check on every cycle that:

- the counter steps by one between overflows;
- a capture hold leaves the channel value untouched;
- a compare hold is never entered in capture mode and never lets a PWM high fall between overflows;
- the full-duty flag changes only at an overflow.

Only the bench scenarios can show the measured duty for each compare value and the coincident match-at-overflow case. The same holds for the exact period in which forcing starts and ends, the value latched for each edge-select and pin-direction pair, and the toggle pattern across two periods.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [1:0] {
        MODE_CAPTURE = 2'b00,
        MODE_TOGGLE  = 2'b01,
        MODE_PWM     = 2'b10,
        MODE_PWM_B   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_e;

    typedef enum logic [1:0] {
        LK_OPEN    = 2'b00,
        LK_CAPHOLD = 2'b01,
        LK_CMPHOLD = 2'b10
    } lock_e;

    typedef struct packed {
        logic  max_req;
        logic  tov;
        edge_e edge_sel;
        mode_e mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] ADDR_HI   = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

endpackage

// File: rtl/tcc_counter.sv
module tcc_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period_max,
    output logic [CW-1:0] cnt,
    output logic          ovf
);

    assign ovf = (cnt >= period_max);

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (ovf) cnt <= '0;
        else          cnt <= cnt + CW'(1);
    end

    // R1: between wraps the count advances by exactly one
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf) |=> (cnt == $past(cnt) + CW'(1)))
        else $error("counter did not step by one");

endmodule

// File: rtl/tcc_edge_detect.sv
module tcc_edge_detect
    import tcc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin,
    input  edge_e sel,
    output logic  hit
);

    logic [SYNC_STAGES:0] chain;
    logic now_lvl, prev_lvl, rise, fall;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-1:0], pin};
    end

    assign now_lvl  = chain[SYNC_STAGES-1];
    assign prev_lvl = chain[SYNC_STAGES];
    assign rise     = now_lvl & ~prev_lvl;
    assign fall     = ~now_lvl & prev_lvl;

    always_comb begin
        unique case (sel)
            EDGE_NONE: hit = 1'b0;
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    // R3: no edge qualifies when the select is off
    assert_hit_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (sel != EDGE_NONE))
        else $error("edge hit with select off");

endmodule

// File: rtl/tcc_regs.sv
module tcc_regs
    import tcc_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          cap_hit,
    input  logic [CW-1:0] count,
    output logic [CW-1:0] chan_val,
    output ctrl_t         ctrl,
    output lock_e         lk
);

    lock_e lk_nx;
    logic  wr_hi, wr_lo, wr_ctl, rd_hi, rd_lo, cap_mode, cap_take;

    assign wr_hi    = wr && (addr == AW'(ADDR_HI));
    assign wr_lo    = wr && (addr == AW'(ADDR_LO));
    assign wr_ctl   = wr && (addr == AW'(ADDR_CTRL));
    assign rd_hi    = rd && (addr == AW'(ADDR_HI));
    assign rd_lo    = rd && (addr == AW'(ADDR_LO));
    assign cap_mode = (ctrl.mode == MODE_CAPTURE);
    assign cap_take = cap_hit && cap_mode && (lk != LK_CAPHOLD) && !rd_hi;

    // lock state register
    always_ff @(posedge clk) begin
        if (!rst_n) lk <= LK_OPEN;
        else        lk <= lk_nx;
    end

    // lock transitions: cap_freeze, cap_release, cmp_freeze, cmp_release
    always_comb begin
        lk_nx = lk;
        unique case (lk)
            LK_OPEN: begin
                if (rd_hi && cap_mode)       lk_nx = LK_CAPHOLD;
                else if (wr_hi && !cap_mode) lk_nx = LK_CMPHOLD;
            end
            LK_CAPHOLD: if (rd_lo || wr_ctl) lk_nx = LK_OPEN;
            LK_CMPHOLD: if (wr_lo || wr_ctl) lk_nx = LK_OPEN;
            default:    lk_nx = LK_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl <= '0;
        else if (wr_ctl) ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // channel value: no reset value by design
    always_ff @(posedge clk) begin
        if (wr_hi) chan_val[CW-1:DW] <= wdata;
        if (wr_lo) chan_val[DW-1:0]  <= wdata;
        if (!wr_hi && !wr_lo && cap_take) chan_val <= count;
    end

    always_comb begin
        case (addr)
            AW'(ADDR_HI):   rdata = chan_val[CW-1:DW];
            AW'(ADDR_LO):   rdata = chan_val[DW-1:0];
            AW'(ADDR_CTRL): rdata = {{(DW-CTRL_W){1'b0}}, ctrl};
            default:        rdata = '0;
        endcase
    end

    // R4: a capture hold freezes the channel value unless the bus writes it
    assert_capture_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lk == LK_CAPHOLD && !wr) |=> $stable(chan_val))
        else $error("capture landed during hold");

    // R6: a compare hold only exists in a compare mode
    assert_cmp_hold_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk == LK_CMPHOLD) |-> (ctrl.mode != MODE_CAPTURE))
        else $error("compare hold in capture mode");

endmodule

// File: rtl/tcc_wave.sv
module tcc_wave
    import tcc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode,
    input  logic          tov,
    input  logic          max_req,
    input  logic          ovf,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] chan_val,
    input  logic          cmp_block,
    output logic          pin_o
);

    logic q, max_act, match, pwm_mode;

    assign match    = !cmp_block && (count == chan_val);
    assign pwm_mode = mode[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= 1'b0;
            max_act <= 1'b0;
        end else begin
            if (ovf) max_act <= max_req;
            unique case (mode)
                MODE_CAPTURE: q <= q;
                MODE_TOGGLE:  if (match) q <= ~q;
                MODE_PWM, MODE_PWM_B: begin
                    if (ovf)        q <= tov ? ~q : 1'b1;
                    else if (match) q <= 1'b0;
                end
                default: q <= q;
            endcase
        end
    end

    assign pin_o = q | (max_act & pwm_mode & ~tov);

    // R7: the full-duty flag only moves at a period boundary
    assert_max_on_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf) |=> $stable(max_act))
        else $error("full-duty flag changed mid-period");

    // R6: a held compare cannot pull a PWM high low before the wrap
    assert_hold_no_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_block && q && !ovf && pwm_mode) |=> q)
        else $error("compare acted during hold");

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
    import tcc_pkg::*;
#(
    parameter int DW          = 8,
    parameter int AW          = 2,
    parameter int SYNC_STAGES = 2,
    localparam int CW         = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [CW-1:0] period_max,
    input  logic          cap_pin,
    output logic [CW-1:0] tmr_count,
    output logic          ch_out
);

    logic          ovf, cap_hit;
    logic [CW-1:0] chan_val;
    ctrl_t         ctrl;
    lock_e         lk;

    tcc_counter #(.CW(CW)) u_counter (
        .clk(clk), .rst_n(rst_n), .period_max(period_max),
        .cnt(tmr_count), .ovf(ovf)
    );

    tcc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin),
        .sel(ctrl.edge_sel), .hit(cap_hit)
    );

    tcc_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
        .wdata(bus_wdata), .rdata(bus_rdata), .cap_hit(cap_hit),
        .count(tmr_count), .chan_val(chan_val), .ctrl(ctrl), .lk(lk)
    );

    tcc_wave #(.CW(CW)) u_wave (
        .clk(clk), .rst_n(rst_n), .mode(ctrl.mode), .tov(ctrl.tov),
        .max_req(ctrl.max_req), .ovf(ovf), .count(tmr_count),
        .chan_val(chan_val), .cmp_block(lk == LK_CMPHOLD), .pin_o(ch_out)
    );

endmodule

// File: tb/tcc_channel_tb.sv
module tcc_channel_tb;

    bit          clk = 1'b0;
    logic        rst_n;
    logic [1:0]  bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [15:0] period_max;
    logic        cap_pin;
    logic [15:0] tmr_count;
    logic        ch_out;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    tcc_channel u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .period_max(period_max), .cap_pin(cap_pin),
        .tmr_count(tmr_count), .ch_out(ch_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // all bus tasks are entered right after a falling edge
    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd16(output int v);
        logic [7:0] h, l;
        rd_reg(2'd0, h);
        rd_reg(2'd1, l);
        v = {h, l};
    endtask

    task automatic wait_count(input int v);
        @(negedge clk);
        while (tmr_count != 16'(v)) @(negedge clk);
    endtask

    task automatic sample_n(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            if (ch_out) highs++;
            @(negedge clk);
        end
    endtask

    task automatic pwm_period(output int highs);
        int tmp;
        wait_count(0);
        sample_n(10, tmp);
        sample_n(10, highs);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int h, h2, v, exp_v, bad;
        rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0;
        bus_wdata = '0; cap_pin = 1'b0; period_max = 16'd9;
        repeat (3) @(negedge clk);

        // R11 reset state
        check(tmr_count == 0, "R11 count in reset", int'(tmr_count), 0);
        check(ch_out == 1'b0, "R11 output in reset", int'(ch_out), 0);
        rd_reg(2'd2, d);
        check(d == 8'h00, "R11 control in reset", int'(d), 0);
        rst_n = 1'b1;

        // R1 counting with modulo 9, then 5
        wait_count(0);
        bad = 0;
        for (int i = 0; i < 25; i++) begin
            if (tmr_count != 16'(i % 10)) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R1 modulo 9 sequence", bad, 0);
        period_max = 16'd5;
        wait_count(0);
        bad = 0;
        for (int i = 0; i < 12; i++) begin
            if (tmr_count != 16'(i % 6)) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R1 modulo 5 sequence", bad, 0);
        period_max = 16'd9;

        // R2 register map
        wr_reg(2'd2, 8'hFF);
        rd_reg(2'd2, d);
        check(d == 8'h3F, "R2 control readback", int'(d), 'h3F);
        rd_reg(2'd3, d);
        check(d == 8'h00, "R2 unused address", int'(d), 0);
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd0, 8'h5A);
        wr_reg(2'd1, 8'h3C);
        rd16(v);
        check(v == 'h5A3C, "R2 channel bytes", v, 'h5A3C);

        // R5 duty sweep over every compare value and beyond modulo
        for (int c = 0; c <= 12; c++) begin
            wr_reg(2'd2, 8'h02);
            wr_reg(2'd0, 8'h00);
            wr_reg(2'd1, 8'(c));
            pwm_period(h);
            check(h == ((c >= 9) ? 10 : c + 1), "R5 pwm duty", h, (c >= 9) ? 10 : c + 1);
        end

        // R2 mode 11 is also PWM
        wr_reg(2'd2, 8'h03);
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'd4);
        pwm_period(h);
        check(h == 5, "R2 mode 11 pwm", h, 5);

        // R6 compare hold
        wr_reg(2'd2, 8'h02);
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'd2);
        pwm_period(h);
        check(h == 3, "R6 baseline duty", h, 3);
        wr_reg(2'd0, 8'h00);
        wait_count(0);
        sample_n(10, h);
        check(h == 10, "R6 compare held", h, 10);
        wr_reg(2'd1, 8'd2);
        pwm_period(h);
        check(h == 3, "R6 compare released", h, 3);

        // R7 / R8 full-duty latency
        wait_count(4);
        wr_reg(2'd2, 8'h22);
        sample_n(5, h);
        check(h == 0, "R7 write period unchanged", h, 0);
        sample_n(4, h);
        wr_reg(2'd2, 8'h02);
        sample_n(5, h2);
        check(h + h2 == 9, "R7 forced next period", h + h2, 9);
        sample_n(10, h);
        check(h == 3, "R8 released after wrap", h, 3);

        // R9 toggle-on-overflow ignores full-duty
        wr_reg(2'd2, 8'h32);
        pwm_period(h);
        check(h == 3, "R9 no forcing with tov", h, 3);

        // R10 toggle mode
        wr_reg(2'd2, 8'h01);
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'd3);
        wait_count(0);
        sample_n(10, h);
        sample_n(10, h2);
        check(h + h2 == 10, "R10 two-period high total", h + h2, 10);
        check(h == 4 || h == 6, "R10 toggle phase", h, 4);

        // R3 edge-select sweep
        for (int sel = 0; sel < 4; sel++) begin
            wr_reg(2'd2, 8'(sel << 2));
            for (int dir = 0; dir < 2; dir++) begin
                bit qual;
                cap_pin = (dir == 1);
                repeat (4) @(negedge clk);
                wr_reg(2'd0, 8'hAB);
                wr_reg(2'd1, 8'hCD);
                cap_pin = ~cap_pin;
                @(negedge clk); @(negedge clk);
                exp_v = int'(tmr_count);
                repeat (3) @(negedge clk);
                rd16(v);
                qual = (sel == 3) || (sel == 1 && dir == 0) || (sel == 2 && dir == 1);
                if (!qual) exp_v = 'hABCD;
                check(v == exp_v, "R3 capture by edge select", v, exp_v);
            end
        end

        // R4 capture hold
        wr_reg(2'd2, 8'h0C);
        cap_pin = 1'b0;
        repeat (4) @(negedge clk);
        wr_reg(2'd0, 8'hAB);
        wr_reg(2'd1, 8'hCD);
        rd_reg(2'd0, d);
        check(d == 8'hAB, "R4 high byte", int'(d), 'hAB);
        cap_pin = 1'b1;
        repeat (5) @(negedge clk);
        rd_reg(2'd1, d);
        check(d == 8'hCD, "R4 low byte coherent", int'(d), 'hCD);
        rd16(v);
        check(v == 'hABCD, "R4 capture blocked", v, 'hABCD);
        cap_pin = 1'b0;
        @(negedge clk); @(negedge clk);
        exp_v = int'(tmr_count);
        repeat (3) @(negedge clk);
        rd16(v);
        check(v == exp_v, "R4 capture after release", v, exp_v);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule